// File: doc/BRIEF.md
# PRBS Pattern Generator and Error Checker

This block drives one bit per clock of a 31-stage pseudo-random sequence (feedback taps at stages 31 and 28) and checks one received bit per clock against the same sequence. The checker needs no seed: it fills its shift register from the incoming bits, predicts each following bit, and declares lock once enough predictions in a row are correct. While it is locked it predicts from its own state, so one corrupted line bit counts as exactly one error. Each side has its own enable and its own polarity select.

Mismatches go into a 32-bit saturating error counter. Software reads the counter as two 16-bit halves through a three-register interface with plain read and write strobes. The interface is built so that the two halves always belong together: reading the low half also copies the upper half of that same count into the high register. The count can also be held back until the checker has locked once. The count is zeroed only by a self-clearing control bit.

Top module: `prbs_pattern_unit`

## Requirements
- R1: Register map by `addr`: 0 is control, 1 is the low 16 bits of the error count, 2 is the high-half snapshot. Control bits: 0 generator enable, 1 checker enable, 4 clear (write-only strobe), 5 count-after-lock mode, 6 generator polarity, 7 checker polarity. Bits 15:8, 4, 3 and 2 always read as 0, so writing 0xFFFF reads back 0x00E3.
- R2: After reset, all three registers read 0 and `tx_bit` is 0. While the generator is disabled, `tx_bit` stays 0.
- R3: With the generator enabled and bit 6 = 1, the `tx_bit` stream t satisfies t[n] = t[n-31] XOR t[n-28]. With bit 6 = 0, it satisfies t[n] = NOT(t[n-31] XOR t[n-28]).
- R4: With `tx_bit` looped to `rx_bit` at matching polarity, the checker locks and counts nothing. Each isolated flipped received bit then adds exactly 1 to the count.
- R5: With the two polarity bits different and count-after-lock off, the checker never locks. Once it has loaded 31 bits after being enabled, every later bit adds 1 to the count.
- R6: While locked, the 8th mismatch within 64 bits (counted from the first mismatch) drops lock. The checker then reloads 31 received bits without counting before it compares again.
- R7: Writing control with bit 4 = 1 zeroes the count and the high snapshot in that cycle. Bit 4 reads back as 0.
- R8: Reading either count register never changes the count.
- R9: A read of address 1 returns the live low half and, at the same clock edge, copies the upper half of that same count into address 2. Address 2 keeps that value until the next read of address 1 or the next clear.
- R10: With bit 5 = 1, nothing is counted until the checker has been locked once since the last clear or the last time the checker was disabled. After that, counting continues even when lock is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for the snapshot side effect) |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| tx_bit | output | 1 | Generated pattern bit |
| rx_bit | input | 1 | Received bit under test |

## Verification
The hardest state to reach from the ports is a high snapshot that is nonzero and differs from the live count. That needs more than 65,535 counted errors. The bench gets there quickly by setting the two polarities opposite: the checker then never locks, and it scores an error on every clock, so the exact count follows directly from the cycle number. Lock loss and the arming that survives it are reached by flipping the checker polarity while it is locked. This produces exactly eight locked-mode errors, then a silent refill, then an error every cycle, which gives a precise expected count at two chosen read times.

// File: rtl/prbs_pu_pkg.sv
package prbs_pu_pkg;

  localparam int LFSR_W = 31;
  localparam int TAP_HI = 31;
  localparam int TAP_LO = 28;
  localparam int REG_W  = 16;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 2'd2;

  localparam int BIT_GEN_EN   = 0;
  localparam int BIT_CHK_EN   = 1;
  localparam int BIT_CLR      = 4;
  localparam int BIT_AFTER_LK = 5;
  localparam int BIT_GEN_NORM = 6;
  localparam int BIT_CHK_NORM = 7;

  localparam logic [REG_W-1:0] CTRL_RD_MASK = 16'h00E3;

  typedef struct packed {
    logic chk_norm;
    logic gen_norm;
    logic after_lock;
    logic chk_en;
    logic gen_en;
  } ctrl_t;

  // Next sequence bit predicted from a shift register holding the last LFSR_W bits.
  function automatic logic lfsr_fb(input logic [LFSR_W-1:0] s);
    return s[TAP_HI-1] ^ s[TAP_LO-1];
  endfunction

  // Saturating increment.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

endpackage

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_pu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic norm,
  output logic tx_bit
);

  localparam logic [LFSR_W-1:0] SEED = '1;

  logic [LFSR_W-1:0] state;
  logic              fb;

  assign fb = lfsr_fb(state);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      state  <= SEED;
      tx_bit <= 1'b0;
    end else begin
      state  <= {state[LFSR_W-2:0], fb};
      tx_bit <= fb ^ ~norm;
    end
  end

endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
  import prbs_pu_pkg::*;
#(
  parameter int LOCK_RUN  = 32,
  parameter int LOSS_ERRS = 8,
  parameter int LOSS_WIN  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic norm,
  input  logic rx_bit,
  output logic err_evt,
  output logic locked
);

  localparam int RUN_W  = $clog2(LOCK_RUN);
  localparam int BAD_W  = $clog2(LOSS_ERRS + 1);
  localparam int WIN_W  = $clog2(LOSS_WIN);
  localparam int FILL_W = $clog2(LFSR_W + 1);
  localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(LOCK_RUN - 1);
  localparam logic [BAD_W-1:0]  LOSS_LIM  = BAD_W'(LOSS_ERRS);
  localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(LOSS_WIN - 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(LFSR_W);

  logic [LFSR_W-1:0] sh;
  logic [FILL_W-1:0] fill;
  logic [RUN_W-1:0]  run;
  logic [BAD_W-1:0]  bad;
  logic [WIN_W-1:0]  win;
  logic              rx_c, pred, filled, miss;
  logic [BAD_W-1:0]  bad_nx;

  assign rx_c    = rx_bit ^ ~norm;
  assign pred    = lfsr_fb(sh);
  assign filled  = (fill == FILL_FULL);
  assign miss    = filled && (pred != rx_c);
  assign err_evt = en && miss;
  assign bad_nx  = bad + BAD_W'(miss);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      sh     <= '0;
      fill   <= '0;
      run    <= '0;
      bad    <= '0;
      win    <= '0;
      locked <= 1'b0;
    end else begin
      sh <= {sh[LFSR_W-2:0], locked ? pred : rx_c};
      if (!filled) fill <= fill + 1'b1;
      if (!locked) begin
        if (!filled || miss) begin
          run <= '0;
        end else if (run == RUN_LAST) begin
          locked <= 1'b1;
          run    <= '0;
          bad    <= '0;
          win    <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        if (bad_nx >= LOSS_LIM) begin
          locked <= 1'b0;
          fill   <= '0;
          bad    <= '0;
          win    <= '0;
        end else if (bad_nx != '0) begin
          if (win == WIN_LAST) begin
            bad <= '0;
            win <= '0;
          end else begin
            bad <= bad_nx;
            win <= win + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/prbs_err_cnt.sv
module prbs_err_cnt
  import prbs_pu_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   err_evt,
  input  logic                   after_lock,
  input  logic                   locked,
  input  logic                   chk_en,
  input  logic                   rd_lo,
  output logic [CNT_W-1:0]       cnt,
  output logic [CNT_W-REG_W-1:0] hi_snap,
  output logic                   armed
);

  logic gate;

  assign gate = !after_lock || armed || locked;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !chk_en) armed <= 1'b0;
    else if (locked)              armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)           cnt <= '0;
    else if (err_evt && gate)    cnt <= sat_inc(cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) hi_snap <= '0;
    else if (rd_lo)    hi_snap <= cnt[CNT_W-1:REG_W];
  end

endmodule

// File: rtl/prbs_pattern_unit.sv
module prbs_pattern_unit
  import prbs_pu_pkg::*;
#(
  parameter int LOCK_RUN  = 32,
  parameter int LOSS_ERRS = 8,
  parameter int LOSS_WIN  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              tx_bit,
  input  logic              rx_bit
);

  ctrl_t                  ctrl_q;
  logic                   ctrl_wr, clr_wr, rd_lo;
  logic                   err_evt, locked, armed;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-REG_W-1:0] hi_snap;
  logic [REG_W-1:0]       ctrl_view;

  assign ctrl_wr = wr_en && (addr == ADDR_CTRL);
  assign clr_wr  = ctrl_wr && wdata[BIT_CLR];
  assign rd_lo   = rd_en && (addr == ADDR_CNT_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.chk_norm   <= wdata[BIT_CHK_NORM];
      ctrl_q.gen_norm   <= wdata[BIT_GEN_NORM];
      ctrl_q.after_lock <= wdata[BIT_AFTER_LK];
      ctrl_q.chk_en     <= wdata[BIT_CHK_EN];
      ctrl_q.gen_en     <= wdata[BIT_GEN_EN];
    end
  end

  always_comb begin
    ctrl_view               = '0;
    ctrl_view[BIT_CHK_NORM] = ctrl_q.chk_norm;
    ctrl_view[BIT_GEN_NORM] = ctrl_q.gen_norm;
    ctrl_view[BIT_AFTER_LK] = ctrl_q.after_lock;
    ctrl_view[BIT_CHK_EN]   = ctrl_q.chk_en;
    ctrl_view[BIT_GEN_EN]   = ctrl_q.gen_en;
  end

  always_comb begin
    case (addr)
      ADDR_CTRL:   rdata = ctrl_view;
      ADDR_CNT_LO: rdata = cnt[REG_W-1:0];
      ADDR_CNT_HI: rdata = hi_snap;
      default:     rdata = '0;
    endcase
  end

  prbs_gen u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (ctrl_q.gen_en),
    .norm   (ctrl_q.gen_norm),
    .tx_bit (tx_bit)
  );

  prbs_chk #(
    .LOCK_RUN  (LOCK_RUN),
    .LOSS_ERRS (LOSS_ERRS),
    .LOSS_WIN  (LOSS_WIN)
  ) u_chk_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_q.chk_en),
    .norm    (ctrl_q.chk_norm),
    .rx_bit  (rx_bit),
    .err_evt (err_evt),
    .locked  (locked)
  );

  prbs_err_cnt u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr_wr),
    .err_evt    (err_evt),
    .after_lock (ctrl_q.after_lock),
    .locked     (locked),
    .chk_en     (ctrl_q.chk_en),
    .rd_lo      (rd_lo),
    .cnt        (cnt),
    .hi_snap    (hi_snap),
    .armed      (armed)
  );

endmodule

// File: rtl/prbs_pattern_unit_chk.sv
module prbs_pattern_unit_chk
  import prbs_pu_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      addr,
  input logic [REG_W-1:0]       rdata,
  input logic                   tx_bit,
  input logic                   gen_en,
  input logic                   after_lock,
  input logic                   clr_wr,
  input logic                   rd_lo,
  input logic                   err_evt,
  input logic                   locked,
  input logic                   armed,
  input logic [CNT_W-1:0]       cnt,
  input logic [CNT_W-REG_W-1:0] hi_snap
);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_CTRL) |-> ((rdata & ~CTRL_RD_MASK) == '0));

  a_r2_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !tx_bit);

  a_r4_count_only_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_evt && !clr_wr) |=> $stable(cnt));

  a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (cnt == '0) && (hi_snap == '0));

  a_r8_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (cnt >= $past(cnt)));

  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !clr_wr) |=> (hi_snap == $past(cnt[CNT_W-1:REG_W])));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !clr_wr) |=> $stable(hi_snap));

  a_r10_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (after_lock && !armed && !locked && !clr_wr) |=> $stable(cnt));

  a_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt) && !clr_wr) |=> (&cnt));

endmodule

bind prbs_pattern_unit prbs_pattern_unit_chk u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .rdata      (rdata),
  .tx_bit     (tx_bit),
  .gen_en     (ctrl_q.gen_en),
  .after_lock (ctrl_q.after_lock),
  .clr_wr     (clr_wr),
  .rd_lo      (rd_lo),
  .err_evt    (err_evt),
  .locked     (locked),
  .armed      (armed),
  .cnt        (cnt),
  .hi_snap    (hi_snap)
);

// File: tb/prbs_pattern_unit_tb.sv
`timescale 1ns/1ps
module prbs_pattern_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        tx_bit;
  logic        rx_bit;
  logic        inj = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic bits [0:119];

  always #2.5 clk = ~clk;
  assign rx_bit = tx_bit ^ inj;

  prbs_pattern_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_bit(tx_bit), .rx_bit(rx_bit)
  );

  // Expected relations, restated independently of the RTL
  function automatic logic seq_next(input logic a31, input logic a28, input logic normal);
    return normal ? (a31 ^ a28) : ~(a31 ^ a28);
  endfunction

  // Errors after N clocks of opposite polarity, starting from an empty checker
  function automatic int mism_count(input int n);
    return (n >= 32) ? n - 31 : 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flip_one;
    @(negedge clk); inj = 1'b1;
    @(negedge clk); inj = 1'b0;
  endtask

  task automatic collect_and_check(input logic normal, input string req);
    int bad = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk); bits[i] = tx_bit;
    end
    for (int i = 40; i < 120; i++)
      if (bits[i] !== seq_next(bits[i-31], bits[i-28], normal)) bad++;
    check(req, bad, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    int k, j, gap;
    k = $urandom(32'd7331);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(2'd0, v); check("R2 ctrl reset", v, 16'h0000);
    rd(2'd1, v); check("R2 lo reset", v, 16'h0000);
    rd(2'd2, v); check("R2 hi reset", v, 16'h0000);
    check("R2 tx reset", tx_bit, 1'b0);

    // R1 reserved and strobe bits read zero
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); check("R1 ctrl readback", v, 16'h00E3);
    wr(2'd0, 16'h0000);

    // R3 generator sequence, both polarities
    wr(2'd0, 16'h0041);
    collect_and_check(1'b1, "R3 normal sequence");
    wr(2'd0, 16'h0001);
    collect_and_check(1'b0, "R3 inverted sequence");
    wr(2'd0, 16'h0000);
    wait_cyc(2);
    begin
      int ones = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); ones += tx_bit; end
      check("R2 tx idle when disabled", ones, 0);
    end

    // R4 locked loopback counts isolated flips exactly
    wr(2'd0, 16'h00C3);
    wait_cyc(200);
    wr(2'd0, 16'h00D3);
    rd(2'd1, v); check("R7 count zero after clear", v, 16'd0);
    k = $urandom_range(2, 6);
    for (int i = 0; i < k; i++) begin
      gap = $urandom_range(80, 150);
      wait_cyc(gap);
      flip_one();
    end
    wait_cyc(100);
    rd(2'd1, v);  check("R4 one count per flip", v, k);
    rd(2'd1, v2); check("R8 read does not clear", v2, k);
    rd(2'd2, v);  check("R9 hi snapshot small count", v, 16'd0);

    // R6 lock loss after 8 errors, then R10 counting continues after loss
    wr(2'd0, 16'h0073);
    wait_cyc(19);
    rd(2'd1, v); check("R6 eight errors then resync", v, 16'd8);
    wait_cyc(178);
    rd(2'd1, v); check("R10 armed count continues", v, 16'd169);

    // R10 disabling the checker disarms the gate
    wr(2'd0, 16'h0041);
    rd(2'd1, v);
    wr(2'd0, 16'h0063);
    wait_cyc(300);
    rd(2'd1, v2); check("R10 disarmed by disable", v2, v);

    // R5 / R9 free-running mismatch count beyond 16 bits
    wr(2'd0, 16'h0001);
    wr(2'd0, 16'h0093);
    j = 70000 + $urandom_range(0, 500);
    wait_cyc(j);
    rd(2'd2, v); check("R9 hi not tracking", v, 16'd0);
    rd(2'd1, v); check("R5 every bit counted", v, mism_count(j + 3) & 32'hFFFF);
    rd(2'd2, v); check("R9 hi captured", v, mism_count(j + 3) >> 16);
    rd(2'd1, v); check("R8 count keeps running", v, mism_count(j + 7) & 32'hFFFF);
    rd(2'd0, v); check("R7 clear bit reads zero", v, 16'h0083);

    // R10 gated mode never counts without lock; free mode counts at once
    wr(2'd0, 16'h0001);
    wr(2'd0, 16'h00B3);
    wait_cyc(300);
    rd(2'd1, v); check("R10 held before lock", v, 16'd0);
    wr(2'd0, 16'h0083);
    wait_cyc(20);
    rd(2'd1, v); check("R5 free mode counts", v, 16'd21);

    summary();
    $finish;
  end

endmodule